// File: doc/BRIEF.md
# Disk Sector Write Formatter

This block turns one disk sector into a serial stream of write pulses. A one-cycle start strobe launches the sector. The block then walks a fixed layout of three records: a short header, a label and a large data record. Each record is framed by a zero-filled lead-in, a one-word sync marker, the record words, a checksum word and a zero-filled tail. The first record has a much longer lead-in than the other two, which leaves room for the drive to settle after the sector mark.

Record words come from an external buffer that the block reads as it goes, one word at a time. A record is read from its highest address down to its lowest. Each record's checksum is the disk address XORed with every word of that record. Words are shifted out most significant bit first.

On the line, every bit cell opens with a one-cycle clock pulse. A second one-cycle pulse is placed partway through the cell when the bit is one. The cell length and the data-pulse offset are parameters counted in system clocks. The defaults, 60 and 30 at 100 MHz, give a 600 ns cell.

Top module: `sector_write_fmt`

## Requirements
- R1: After reset, `busy_o`, `pulse_o`, `overrun_o` and `buf_rd_o` are all low.
- R2: A `start_i` strobe while idle raises `busy_o` on the next cycle. `busy_o` then stays high for exactly (total sector bits) x `CELL_CYC` cycles. With the default layout the sector is 5232 bits.
- R3: The stream is built as follows. Record 0 (header) is 34 zero words, a sync word 0x0001, 2 record words, a checksum word and 5 zero words. Record 1 (label) is 3 zero words, sync, 8 record words, checksum and 5 zero words. Record 2 (data) is 3 zero words, sync, 256 record words, checksum and 5 zero words.
- R4: Each record's checksum word equals the XOR of all words of that record and `disk_addr_i`. `disk_addr_i` is sampled in the cycle the start strobe is accepted, so later changes have no effect on that sector.
- R5: Every 16-bit word is sent most significant bit first, so the sync word 0x0001 appears as fifteen zero cells followed by a one cell.
- R6: Record words are read highest address first, down to address 0. A read is a one-cycle `buf_rd_o` strobe carrying `buf_rec_o` (0 header, 1 label, 2 data) and `buf_addr_o`. `buf_data_i` must hold the word in the following cycle. The strobe comes in the cycle just before the clock pulse of the last bit cell of the preceding word.
- R7: Clock pulses are one cycle wide and exactly `CELL_CYC` cycles apart. The first comes in the cycle after `busy_o` rises. A data pulse follows its clock pulse by `DATA_POS` cycles only when the bit is one. The last clock pulse comes `CELL_CYC`-1 cycles before `busy_o` falls.
- R8: While `busy_o` is low there are no pulses and no buffer reads.
- R9: A `start_i` strobe while busy does not alter the sector in progress. It sets `overrun_o` on the next cycle, and `overrun_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sector-start strobe |
| disk_addr_i | input | WORD_W | Disk address that seeds every record checksum |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_rec_o | output | 2 | Record being read: 0 header, 1 label, 2 data |
| buf_addr_o | output | AW | Word address within the record |
| buf_data_i | input | WORD_W | Buffer word, valid the cycle after the read strobe |
| pulse_o | output | 1 | Combined clock/data write pulse |
| busy_o | output | 1 | High while a sector is being sent |
| overrun_o | output | 1 | Sticky flag: start strobe arrived while busy |

## Verification
Two situations are hardest to reach from the ports. One is a start strobe landing in the middle of a sector. The other is a disk address that changes after the start has been taken. Both must leave a stream of more than five thousand bits unchanged, down to the last checksum. The bench drives both during the first sector, thousands of cycles after the start. It decodes every pulse back into words and compares each word against a model built from the buffer contents and the address sampled at the start. A second sector uses all-ones data to exercise the densest pulse pattern. A third stores each word's own address as its value, which exposes any slip in the reverse-order reads.

// File: rtl/swf_pkg.sv
// Shared types for the sector write formatter.
package swf_pkg;
    // Kind of word inside one record frame, in transmission order.
    typedef enum logic [2:0] {
        SEG_PRE  = 3'd0,
        SEG_SYNC = 3'd1,
        SEG_REC  = 3'd2,
        SEG_CSUM = 3'd3,
        SEG_POST = 3'd4
    } seg_e;
endpackage

// File: rtl/swf_cell_timer.sv
// Bit-cell timer: divides the system clock into cells of CELL_CYC cycles.
// Assumes 2 <= DATA_POS <= CELL_CYC-2 and CELL_CYC >= 4.
// The counter is held at zero while run is low, so a new run always
// starts on a cell boundary.
module swf_cell_timer #(
    parameter int CELL_CYC = 60,
    parameter int DATA_POS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cell_first,
    output logic cell_mid,
    output logic cell_last
);
    localparam int CW = $clog2(CELL_CYC);

    logic [CW-1:0] cnt_q;

    // Cycle position inside the current bit cell.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(CELL_CYC - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cell_first = run && (cnt_q == '0);
    assign cell_mid   = run && (cnt_q == CW'(DATA_POS));
    assign cell_last  = run && (cnt_q == CW'(CELL_CYC - 1));
endmodule

// File: rtl/swf_sequencer.sv
// Sector sequencer: tracks record, frame segment, word and bit position.
// It issues a load at each word boundary, tagged with the kind of the next
// word. It asks for a buffer read at the start of the last bit cell of a
// word whose successor is a record word. Record words go highest address
// first.
module swf_sequencer
    import swf_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int PRE0_LEN = 34,
    parameter int PRE_LEN  = 3,
    parameter int POST_LEN = 5,
    parameter int HDR_LEN  = 2,
    parameter int LBL_LEN  = 8,
    parameter int DAT_LEN  = 256,
    parameter int AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cell_first,
    input  logic          cell_last,
    output logic          load,
    output seg_e          load_seg,
    output logic          done,
    output logic          fetch,
    output logic [1:0]    fetch_rec,
    output logic [AW-1:0] fetch_addr
);
    localparam int MAXA = (PRE0_LEN > DAT_LEN) ? PRE0_LEN : DAT_LEN;
    localparam int MAXB = (LBL_LEN > HDR_LEN) ? LBL_LEN : HDR_LEN;
    localparam int MAXC = (PRE_LEN > POST_LEN) ? PRE_LEN : POST_LEN;
    localparam int MAXD = (MAXB > MAXC) ? MAXB : MAXC;
    localparam int MAXL = (MAXA > MAXD) ? MAXA : MAXD;
    localparam int CW   = $clog2(MAXL + 1);
    localparam int BW   = $clog2(WORD_W);

    logic [1:0]    rec_q, nrec;
    seg_e          seg_q, nseg;
    logic [CW-1:0] wcnt_q, nw;
    logic [BW-1:0] bcnt_q;
    logic          last_word, last_bit, word_end;

    // Number of words in record r.
    function automatic logic [CW-1:0] rec_len(input logic [1:0] r);
        case (r)
            2'd0:    return CW'(HDR_LEN);
            2'd1:    return CW'(LBL_LEN);
            default: return CW'(DAT_LEN);
        endcase
    endfunction

    // Number of words in segment s of record r.
    function automatic logic [CW-1:0] seg_len(input logic [1:0] r, input seg_e s);
        case (s)
            SEG_PRE:            return (r == 2'd0) ? CW'(PRE0_LEN) : CW'(PRE_LEN);
            SEG_SYNC, SEG_CSUM: return CW'(1);
            SEG_REC:            return rec_len(r);
            default:            return CW'(POST_LEN);
        endcase
    endfunction

    assign last_word = (wcnt_q == seg_len(rec_q, seg_q) - CW'(1));
    assign last_bit  = (bcnt_q == BW'(WORD_W - 1));
    assign word_end  = cell_last && last_bit;

    // Position of the word that follows the current one.
    always_comb begin
        nrec = rec_q;
        nseg = seg_q;
        nw   = wcnt_q + CW'(1);
        if (last_word) begin
            nw = '0;
            case (seg_q)
                SEG_PRE:  nseg = SEG_SYNC;
                SEG_SYNC: nseg = SEG_REC;
                SEG_REC:  nseg = SEG_CSUM;
                SEG_CSUM: nseg = SEG_POST;
                default: begin
                    nseg = SEG_PRE;
                    nrec = rec_q + 2'd1;
                end
            endcase
        end
    end

    assign done       = word_end && last_word && (seg_q == SEG_POST) && (rec_q == 2'd2);
    assign load       = word_end && !done;
    assign load_seg   = nseg;
    assign fetch      = cell_first && last_bit && (nseg == SEG_REC);
    assign fetch_rec  = nrec;
    assign fetch_addr = AW'(rec_len(nrec) - CW'(1) - nw);

    // Advance bit and word position at the end of each cell.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rec_q  <= 2'd0;
            seg_q  <= SEG_PRE;
            wcnt_q <= '0;
            bcnt_q <= '0;
        end else if (cell_last) begin
            bcnt_q <= last_bit ? '0 : bcnt_q + BW'(1);
            if (last_bit) begin
                rec_q  <= nrec;
                seg_q  <= nseg;
                wcnt_q <= nw;
            end
        end
    end
endmodule

// File: rtl/swf_word_path.sv
// Word datapath: shift register for the outgoing word, running record
// checksum, latched disk address and one-word prefetch buffer.
// Assumes the buffer returns data the cycle after a read strobe, and that
// the word boundary comes at least two cycles after that.
module swf_word_path
    import swf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] disk_addr,
    input  logic              load,
    input  seg_e              load_seg,
    input  logic              shift,
    input  logic              fetch,
    input  logic [WORD_W-1:0] buf_data,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sh_q, csum_q, addr_q, pref_q;
    logic              rd_q;

    // Capture the buffer word one cycle after its read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            pref_q <= '0;
        end else begin
            rd_q <= fetch;
            if (rd_q) pref_q <= buf_data;
        end
    end

    // Load, shift and checksum update for the outgoing stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            csum_q <= '0;
            addr_q <= '0;
        end else if (start) begin
            sh_q   <= '0;
            csum_q <= disk_addr;
            addr_q <= disk_addr;
        end else if (load) begin
            case (load_seg)
                SEG_SYNC: begin
                    sh_q   <= WORD_W'(1);
                    csum_q <= addr_q;
                end
                SEG_REC: begin
                    sh_q   <= pref_q;
                    csum_q <= csum_q ^ pref_q;
                end
                SEG_CSUM: sh_q <= csum_q;
                default:  sh_q <= '0;
            endcase
        end else if (shift) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign cur_bit = sh_q[WORD_W-1];
endmodule

// File: rtl/sector_write_fmt.sv
// Sector write formatter top. On an accepted start strobe it sends a full
// three-record sector as clock/data write pulses, reading record words
// from an external buffer with single-cycle latency. A start strobe that
// comes while busy is dropped and flagged in a sticky overrun bit.
module sector_write_fmt #(
    parameter int WORD_W   = 16,
    parameter int CELL_CYC = 60,
    parameter int DATA_POS = 30,
    parameter int PRE0_LEN = 34,
    parameter int PRE_LEN  = 3,
    parameter int POST_LEN = 5,
    parameter int HDR_LEN  = 2,
    parameter int LBL_LEN  = 8,
    parameter int DAT_LEN  = 256,
    localparam int AW      = $clog2(DAT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] disk_addr_i,
    output logic              buf_rd_o,
    output logic [1:0]        buf_rec_o,
    output logic [AW-1:0]     buf_addr_o,
    input  logic [WORD_W-1:0] buf_data_i,
    output logic              pulse_o,
    output logic              busy_o,
    output logic              overrun_o
);
    import swf_pkg::*;

    logic busy_q, over_q, pulse_q;
    logic start_ok;
    logic cell_first, cell_mid, cell_last;
    logic load, done, fetch, cur_bit;
    seg_e load_seg;

    assign start_ok = start_i && !busy_q;

    swf_cell_timer #(.CELL_CYC(CELL_CYC), .DATA_POS(DATA_POS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy_q),
        .cell_first(cell_first), .cell_mid(cell_mid), .cell_last(cell_last)
    );

    swf_sequencer #(
        .WORD_W(WORD_W), .PRE0_LEN(PRE0_LEN), .PRE_LEN(PRE_LEN),
        .POST_LEN(POST_LEN), .HDR_LEN(HDR_LEN), .LBL_LEN(LBL_LEN),
        .DAT_LEN(DAT_LEN), .AW(AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_ok),
        .cell_first(cell_first), .cell_last(cell_last),
        .load(load), .load_seg(load_seg), .done(done),
        .fetch(fetch), .fetch_rec(buf_rec_o), .fetch_addr(buf_addr_o)
    );

    swf_word_path #(.WORD_W(WORD_W)) u_path (
        .clk(clk), .rst_n(rst_n), .start(start_ok), .disk_addr(disk_addr_i),
        .load(load), .load_seg(load_seg), .shift(cell_last && !load),
        .fetch(fetch), .buf_data(buf_data_i), .cur_bit(cur_bit)
    );

    // Busy window and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            over_q <= 1'b0;
        end else begin
            if (start_ok)     busy_q <= 1'b1;
            else if (done)    busy_q <= 1'b0;
            if (start_i && busy_q) over_q <= 1'b1;
        end
    end

    // One-cycle write pulse: clock at cell start, data mid-cell on a one.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= cell_first || (cell_mid && cur_bit);
    end

    assign buf_rd_o  = fetch;
    assign pulse_o   = pulse_q;
    assign busy_o    = busy_q;
    assign overrun_o = over_q;
endmodule

// File: rtl/sector_write_fmt_checks.sv
// Property checker for sector_write_fmt, attached by bind.
module sector_write_fmt_checks (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic pulse_o,
    input logic overrun_o,
    input logic buf_rd_o
);
    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r6_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> !buf_rd_o);
    a_r6_read_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> pulse_o);
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    a_r7_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> pulse_o);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pulse_o && !buf_rd_o));
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> overrun_o);
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
endmodule

bind sector_write_fmt sector_write_fmt_checks u_checks (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .pulse_o(pulse_o), .overrun_o(overrun_o), .buf_rd_o(buf_rd_o)
);

// File: tb/sector_write_fmt_tb.sv
// Scoreboard bench: the driver pushes expected words and reads, the
// monitor decodes pulses back into words and compares.
module sector_write_fmt_tb;
    localparam int CELL = 6;
    localparam int DPOS = 3;
    localparam int NBITS = 327 * 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] disk_addr_i = '0;
    logic        buf_rd_o;
    logic [1:0]  buf_rec_o;
    logic [7:0]  buf_addr_o;
    logic [15:0] buf_data_i = '0;
    logic        pulse_o, busy_o, overrun_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] mem [3][256];
    logic [15:0] exp_w[$];
    string       exp_tag[$];
    logic [9:0]  exp_rd[$];

    sector_write_fmt #(.CELL_CYC(CELL), .DATA_POS(DPOS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .disk_addr_i(disk_addr_i),
        .buf_rd_o(buf_rd_o), .buf_rec_o(buf_rec_o), .buf_addr_o(buf_addr_o),
        .buf_data_i(buf_data_i), .pulse_o(pulse_o), .busy_o(busy_o),
        .overrun_o(overrun_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Buffer model with one-cycle read latency.
    always @(posedge clk) if (buf_rd_o) buf_data_i <= mem[buf_rec_o][buf_addr_o];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push_w(input logic [15:0] w, input string tag);
        exp_w.push_back(w);
        exp_tag.push_back(tag);
    endtask

    // Driver: expected sector contents from the buffer and address.
    task automatic push_sector(input logic [15:0] a);
        for (int r = 0; r < 3; r++) begin
            automatic int plen = (r == 0) ? 34 : 3;
            automatic int rlen = (r == 0) ? 2 : (r == 1) ? 8 : 256;
            automatic logic [15:0] cs = a;
            for (int i = 0; i < plen; i++) push_w(16'h0, "R3 preamble");
            push_w(16'h0001, "R3 R5 sync");
            for (int i = rlen - 1; i >= 0; i--) begin
                push_w(mem[r][i], "R6 record word");
                cs ^= mem[r][i];
                exp_rd.push_back({2'(r), 8'(i)});
            end
            push_w(cs, "R4 checksum");
            for (int i = 0; i < 5; i++) push_w(16'h0, "R3 postamble");
        end
    endtask

    task automatic start_sector(input logic [15:0] a);
        @(negedge clk);
        disk_addr_i = a;
        push_sector(a);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor state.
    bit    in_cell = 0, one = 0, prev_busy = 0;
    int    last_clk = 0, rise_cyc = 0, rd_cyc = -10, nbits = 0;
    logic [15:0] acc = '0;

    task automatic finish_bit(input bit b);
        acc = {acc[14:0], b};
        nbits++;
        if (nbits % 16 == 0) begin
            if (exp_w.size() == 0) begin
                chk(0, "R3 extra word", acc, 0);
            end else begin
                automatic logic [15:0] e = exp_w.pop_front();
                automatic string t = exp_tag.pop_front();
                chk(acc == e, t, acc, e);
            end
        end
    endtask

    // Monitor: decode pulses into bits and words, check reads and timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !prev_busy) begin
                rise_cyc = cyc; in_cell = 0; nbits = 0;
            end
            if (!busy_o && (pulse_o || buf_rd_o))
                chk(0, "R8 activity while idle", {pulse_o, buf_rd_o}, 0);
            if (buf_rd_o) begin
                if (exp_rd.size() == 0) chk(0, "R6 extra read", {buf_rec_o, buf_addr_o}, 0);
                else begin
                    automatic logic [9:0] e = exp_rd.pop_front();
                    chk({buf_rec_o, buf_addr_o} == e, "R6 read order", {buf_rec_o, buf_addr_o}, e);
                end
                rd_cyc = cyc;
            end
            if (pulse_o) begin
                if (!in_cell) begin
                    chk(cyc == rise_cyc + 1, "R7 first clock", cyc - rise_cyc, 1);
                    in_cell = 1; last_clk = cyc; one = 0;
                end else if (cyc - last_clk == DPOS && !one) begin
                    one = 1;
                end else if (cyc - last_clk == CELL) begin
                    finish_bit(one);
                    if (rd_cyc == cyc - 1) chk(nbits % 16 == 15, "R6 read timing", nbits % 16, 15);
                    last_clk = cyc; one = 0;
                end else begin
                    chk(0, "R7 pulse spacing", cyc - last_clk, CELL);
                end
            end
            if (prev_busy && !busy_o) begin
                if (in_cell) finish_bit(one);
                chk(cyc - last_clk == CELL - 1, "R7 last clock", cyc - last_clk, CELL - 1);
                chk(cyc - rise_cyc == NBITS * CELL, "R2 busy length", cyc - rise_cyc, NBITS * CELL);
                chk(exp_w.size() == 0, "R3 words left", exp_w.size(), 0);
                chk(exp_rd.size() == 0, "R6 reads left", exp_rd.size(), 0);
                in_cell = 0;
            end
            prev_busy = busy_o;
        end else begin
            prev_busy = 0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(pulse_o == 0, "R1 pulse", pulse_o, 0);
        chk(overrun_o == 0, "R1 overrun", overrun_o, 0);
        chk(buf_rd_o == 0, "R1 read", buf_rd_o, 0);
        rst_n = 1'b1;

        // Sector 1: mixed pattern, late address change and a stray start.
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 256; i++) mem[r][i] = 16'(i * 16'h9E37) ^ 16'(r << 12) ^ 16'h00C5;
        start_sector(16'hA5C3);
        repeat (1000) @(negedge clk);
        disk_addr_i = 16'h0F0F;            // R4: must not affect this sector
        repeat (1000) @(negedge clk);
        chk(overrun_o == 0, "R9 no overrun yet", overrun_o, 0);
        start_i = 1'b1;                    // R9: ignored start
        @(negedge clk);
        start_i = 1'b0;
        chk(overrun_o == 1, "R9 overrun set", overrun_o, 1);
        wait_idle();
        chk(overrun_o == 1, "R9 overrun sticky", overrun_o, 1);
        chk(pulse_o == 0 && buf_rd_o == 0, "R8 idle after sector", {pulse_o, buf_rd_o}, 0);

        // Sector 2: dense ones in data, alternating label, zero address.
        mem[0][0] = 16'h8000; mem[0][1] = 16'h0001;
        for (int i = 0; i < 8; i++) mem[1][i] = i[0] ? 16'hAAAA : 16'h5555;
        for (int i = 0; i < 256; i++) mem[2][i] = 16'hFFFF;
        start_sector(16'h0000);
        wait_idle();

        // Reset clears the overrun flag.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(overrun_o == 0, "R1 R9 overrun cleared", overrun_o, 0);
        rst_n = 1'b1;

        // Sector 3: each word holds its own address, all-ones disk address.
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 256; i++) mem[r][i] = 16'(i) | 16'(r << 14);
        start_sector(16'hFFFF);
        wait_idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule